// File: doc/BRIEF.md
# Dual Wiper Serial Control Register

This block is the digital front end of a dual 256-step potentiometer. A host talks to it over three wires: an active-high enable, a serial clock and a data input. While the enable is high, each rising serial clock edge moves one data bit into a 17-bit shift register. When the enable drops, the register contents are decoded into two 8-bit wiper codes and a stack-select flag, which drive the analog array.

When a transfer opens, the shift register is loaded with the settings currently in force. Its far end drives a cascade output that changes on falling serial clock edges. The host can therefore read the settings back while it writes new ones. Several devices can also share one bus, each cascade output feeding the next device's data input.

The serial lines are asynchronous to the system clock. They pass through a synchronizer, and their edges are detected in the system clock domain. Settings are held in flops and are lost on reset.

Top module: `dual_wiper_serial`

## Requirements
- R1: While the enable input is low, serial clock and data activity changes neither the wiper outputs, the stack output nor the content read back in the next transfer.
- R2: With the enable high, each rising serial clock edge shifts the data input into the register. The first bit of a 17-bit frame ends up at register bit 0.
- R3: Frame layout: bit 0 is the stack flag. Bits 1..8 are the wiper-1 code with its MSB at bit 1. Bits 9..16 are the wiper-0 code with its MSB at bit 9. Bits are sent bit 0 first.
- R4: The decoded frame is copied to wiper0_o, wiper1_o and stack_o on the falling edge of the enable input.
- R5: The outputs stay unchanged while a transfer is in progress.
- R6: On the enable rising edge the current settings are loaded into the register. The cascade output presents frame bit 0 before the first serial clock, and the next frame bit after each falling serial clock edge.
- R7: A bit shifted in reappears on the cascade output 17 serial clocks later, so that devices can be chained.
- R8: After reset both wiper codes are 0x80, the stack flag is 0 and the cascade output is 0.
- R9: The cascade output is 0 while the enable input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_en_i | input | 1 | Serial port enable, active high |
| ser_clk_i | input | 1 | Serial clock |
| ser_dat_i | input | 1 | Serial data in |
| wiper0_o | output | 8 | Wiper-0 tap code |
| wiper1_o | output | 8 | Wiper-1 tap code |
| stack_o | output | 1 | Stack-select flag |
| cascade_o | output | 1 | Serial readback and chain output |

## Verification
A corrupted shift register shows up within one frame: every write is checked through the readback stream of the following transfer, bit by bit, in the cascade output. A decode or commit fault shows up on the wiper and stack outputs a few system cycles after the enable falls. A premature commit is caught by sampling the outputs mid-frame. Chained frames of 34 bits show whether the bits leave the far end after exactly 17 clocks.

// File: rtl/dws_pkg.sv
package dws_pkg;
  parameter int unsigned WIPER_W = 8;
  localparam int unsigned FRAME_W = 2 * WIPER_W + 1;
  localparam logic [WIPER_W-1:0] WIPER_RST = {1'b1, {(WIPER_W-1){1'b0}}};

  typedef struct packed {
    logic [WIPER_W-1:0] pot0;
    logic [WIPER_W-1:0] pot1;
    logic               stack;
  } setting_t;

  function automatic setting_t frame_decode(input logic [FRAME_W-1:0] f);
    setting_t s;
    s.stack = f[0];
    for (int i = 0; i < WIPER_W; i++) begin
      s.pot1[WIPER_W-1-i] = f[1+i];
      s.pot0[WIPER_W-1-i] = f[1+WIPER_W+i];
    end
    return s;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_encode(input setting_t s);
    logic [FRAME_W-1:0] f;
    f[0] = s.stack;
    for (int i = 0; i < WIPER_W; i++) begin
      f[1+i]         = s.pot1[WIPER_W-1-i];
      f[1+WIPER_W+i] = s.pot0[WIPER_W-1-i];
    end
    return f;
  endfunction
endpackage

// File: rtl/dws_sync.sv
module dws_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    chain_q[s] <= '0;
      else if (s == 0) chain_q[s] <= d_i;
      else            chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dws_shifter.sv
module dws_shifter
  import dws_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sclk_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] load_frame_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               commit_o,
  output logic               shift_o,
  output logic               cascade_o
);
  logic en_q, sclk_q;
  logic en_rise, en_fall, sclk_rise, sclk_fall;
  logic [FRAME_W-1:0] sr_q;
  logic cas_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      en_q   <= en_i;
      sclk_q <= sclk_i;
    end
  end

  assign en_rise   = en_i & ~en_q;
  assign en_fall   = ~en_i & en_q;
  // serial clock edges only count inside an open transfer
  assign sclk_rise = en_i & en_q & sclk_i & ~sclk_q;
  assign sclk_fall = en_i & en_q & ~sclk_i & sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (en_rise)   sr_q <= load_frame_i;
    else if (sclk_rise) sr_q <= {sdi_i, sr_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cas_q <= 1'b0;
    else if (en_rise)   cas_q <= load_frame_i[0];
    else if (en_fall)   cas_q <= 1'b0;
    else if (sclk_fall) cas_q <= sr_q[0];
  end

  assign frame_o   = sr_q;
  assign commit_o  = en_fall;
  assign shift_o   = sclk_rise;
  assign cascade_o = cas_q;
endmodule

// File: rtl/dual_wiper_serial.sv
module dual_wiper_serial
  import dws_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ser_en_i,
  input  logic               ser_clk_i,
  input  logic               ser_dat_i,
  output logic [WIPER_W-1:0] wiper0_o,
  output logic [WIPER_W-1:0] wiper1_o,
  output logic               stack_o,
  output logic               cascade_o
);
  logic [2:0]         ser_s;
  logic               en_s;
  logic [FRAME_W-1:0] frame;
  logic               commit;
  logic               shift_ev;
  setting_t           set_q;

  dws_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ser_en_i, ser_clk_i, ser_dat_i}),
    .q_o   (ser_s)
  );

  assign en_s = ser_s[2];

  dws_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_s),
    .sclk_i      (ser_s[1]),
    .sdi_i       (ser_s[0]),
    .load_frame_i(frame_encode(set_q)),
    .frame_o     (frame),
    .commit_o    (commit),
    .shift_o     (shift_ev),
    .cascade_o   (cascade_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q.pot0  <= WIPER_RST;
      set_q.pot1  <= WIPER_RST;
      set_q.stack <= 1'b0;
    end else if (commit) begin
      set_q <= frame_decode(frame);
    end
  end

  assign wiper0_o = set_q.pot0;
  assign wiper1_o = set_q.pot1;
  assign stack_o  = set_q.stack;
endmodule

// File: rtl/dws_checker.sv
module dws_checker
  import dws_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_s,
  input logic               shift_ev,
  input logic [FRAME_W-1:0] frame,
  input logic [WIPER_W-1:0] wiper0_o,
  input logic [WIPER_W-1:0] wiper1_o,
  input logic               stack_o,
  input logic               cascade_o
);
  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |=> $stable(frame));

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_ev |=> frame[FRAME_W-2:0] == $past(frame[FRAME_W-1:1]));

  p_stable_xfer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s |=> $stable(wiper0_o) && $stable(wiper1_o) && $stable(stack_o));

  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_s && !$past(en_s)) |-> !cascade_o);

  p_reset_val_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (wiper0_o == WIPER_RST) && (wiper1_o == WIPER_RST) && !stack_o);
endmodule

bind dual_wiper_serial dws_checker i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_s     (en_s),
  .shift_ev (shift_ev),
  .frame    (frame),
  .wiper0_o (wiper0_o),
  .wiper1_o (wiper1_o),
  .stack_o  (stack_o),
  .cascade_o(cascade_o)
);

// File: tb/test_dual_wiper_serial.sv
module test_dual_wiper_serial;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [7:0] wiper0, wiper1;
  logic stack, cascade;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] cur_w0 = 8'h80, cur_w1 = 8'h80;
  logic cur_st = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_wiper_serial i_dual_wiper_serial (
    .clk_i(clk), .rst_ni(rst_ni), .ser_en_i(ser_en), .ser_clk_i(ser_clk),
    .ser_dat_i(ser_dat), .wiper0_o(wiper0), .wiper1_o(wiper1),
    .stack_o(stack), .cascade_o(cascade)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] mk(input logic [7:0] w0, input logic [7:0] w1, input logic st);
    logic [16:0] f;
    f[0] = st;
    for (int i = 0; i < 8; i++) begin
      f[1+i] = w1[7-i];
      f[9+i] = w0[7-i];
    end
    return f;
  endfunction

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic chk_outs(input string req);
    chk(req, {24'd0, wiper0}, {24'd0, cur_w0});
    chk(req, {24'd0, wiper1}, {24'd0, cur_w1});
    chk(req, {31'd0, stack}, {31'd0, cur_st});
  endtask

  task automatic xfer(input logic [63:0] bits, input int n, output logic [63:0] got);
    got = '0;
    ser_en = 1'b1;
    wait_h();
    for (int i = 0; i < n; i++) begin
      ser_dat = bits[i];
      wait_h();
      got[i] = cascade;
      if (i == n/2) chk_outs("R5 mid-transfer");
      ser_clk = 1'b1;
      wait_h();
      ser_clk = 1'b0;
      wait_h();
    end
    ser_en = 1'b0;
    wait_h();
    wait_h();
  endtask

  task automatic write_set(input logic [7:0] w0, input logic [7:0] w1, input logic st);
    logic [63:0] got;
    xfer({47'd0, mk(w0, w1, st)}, 17, got);
    chk("R6 R3 readback", {15'd0, got[16:0]}, {15'd0, mk(cur_w0, cur_w1, cur_st)});
    cur_w0 = w0; cur_w1 = w1; cur_st = st;
    chk_outs("R4 R3 R2 commit");
    chk("R9 idle cascade", {31'd0, cascade}, 32'd0);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_err++; n_chk++;
        $display("FAIL watchdog act=%0d exp<%0d", cyc, WATCHDOG);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] got;
    logic [16:0] fa, fb;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk_outs("R8 reset");
    chk("R8 reset cascade", {31'd0, cascade}, 32'd0);

    for (int k = 0; k < 256; k += 3) begin
      write_set(k[7:0], 8'((k * 37 + 11) & 255), k[1]);
    end
    write_set(8'hff, 8'h00, 1'b1);
    write_set(8'h00, 8'hff, 1'b0);
    write_set(8'h01, 8'h80, 1'b1);

    // R1: activity with enable low
    for (int i = 0; i < 20; i++) begin
      ser_dat = i[0];
      ser_clk = 1'b1; wait_h();
      ser_clk = 1'b0; wait_h();
    end
    chk_outs("R1 ignored");
    chk("R9 R1 cascade idle", {31'd0, cascade}, 32'd0);
    write_set(8'h5a, 8'ha5, 1'b0);

    // R7: 34-bit chained frame
    fa = mk(8'h3c, 8'hc3, 1'b1);
    fb = mk(8'h96, 8'h69, 1'b0);
    xfer({30'd0, fb, fa}, 34, got);
    chk("R6 chain readback", {15'd0, got[16:0]}, {15'd0, mk(cur_w0, cur_w1, cur_st)});
    chk("R7 chain pass-through", {15'd0, got[33:17]}, {15'd0, fa});
    cur_w0 = 8'h96; cur_w1 = 8'h69; cur_st = 1'b0;
    chk_outs("R7 chain commit");

    // R8: reset after use
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    cur_w0 = 8'h80; cur_w1 = 8'h80; cur_st = 1'b0;
    chk_outs("R8 re-reset");
    write_set(8'h12, 8'h34, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule